// File: doc/BRIEF.md
# Multiprocessor-Filtering Serial Receiver

This block turns an asynchronous serial line into characters of 8 or 9 data bits. A baud tick from outside sets the oversampling rate. Each bit is voted from three samples near its centre. A finished character moves into a one-deep holding register. There it waits for a read strobe, and a set of status outputs travels with it: ready, stop-bit error and lost-character.

The lost-character flag is held back. It is not raised against the character that is still unread. It appears with the first character transferred after that one has been read. In address-filter mode, only frames whose mark bit is one reach the register. Software drops the mode once its address is seen and then takes data frames as usual. Clearing the receive enable freezes the flags in their present state. An interrupt request follows the ready flag when the interrupt enable is set.

Top module: `uart_rx_mp`

## Requirements
- R1: The idle line is high. A frame is a low start bit, then data bits with the least significant bit first (8 bits, or 9 when `nine_bit` is 1), then a stop bit. A completed frame loads `rx_data` and sets `rx_done`.
- R2: A bit lasts 16 baud ticks, or 8 when `dbl_speed` is 1. Its value is the majority of the samples on ticks mid-1, mid and mid+1 counted from the start edge, where mid is half the bit length.
- R3: A start is armed only by a high-to-low transition. If the majority vote of the start bit is high, the frame is abandoned and nothing is stored.
- R4: `frame_err` is 1 when the stop bit of the most recently transferred character voted 0, and 0 when it voted 1. It changes only on a transfer.
- R5: `rx_bit8` carries the 9th data bit in 9-bit mode and is 0 in 8-bit mode.
- R6: `rd_strobe` while `rx_done` is 1 clears `rx_done` on the next edge. While `rx_done` is 0 the strobe has no effect.
- R7: A character that completes while `rx_done` is 1 and `rd_strobe` is 0 is discarded, and the register keeps the unread character. `overrun` does not rise at that point. It becomes 1 together with the next character that is transferred. A transfer with no loss pending clears it.
- R8: If a character completes in the same cycle as a read, the new character is transferred, `rx_done` stays 1 and `overrun` is 0.
- R9: With `mp_mode` set, a frame is accepted only if its mark is 1. The mark is the 9th data bit in 9-bit mode and the stop bit in 8-bit mode. A rejected frame changes no output and records no loss.
- R10: While `rx_en` is 0, no frame is received and `rx_done`, `frame_err` and `overrun` cannot be set. Flags already set keep their values, and no loss is recorded.
- R11: `rx_irq` equals `rx_done` AND `rx_irq_en`. It rises on the same edge as `rx_done`.
- R12: After reset, `rx_done`, `frame_err`, `overrun`, `rx_irq`, `rx_bit8` and `rx_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | Oversampling tick, one clock wide |
| rx_in | input | 1 | Asynchronous serial line |
| rx_en | input | 1 | Receiver enable |
| dbl_speed | input | 1 | 8 ticks per bit instead of 16 |
| nine_bit | input | 1 | 9 data bits per frame |
| mp_mode | input | 1 | Accept only frames marked as address |
| rx_irq_en | input | 1 | Interrupt enable for the ready flag |
| rd_strobe | input | 1 | Read of the holding register |
| rx_data | output | 8 | Received data bits 7..0 |
| rx_bit8 | output | 1 | Received 9th bit |
| rx_done | output | 1 | Unread character present |
| frame_err | output | 1 | Stop bit of the held character was low |
| overrun | output | 1 | A character was lost before this one |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
A character can finish in the same cycle as a read strobe for the previous one. The bench first times an unobstructed frame from a fixed tick phase to find the edge at which `rx_done` rises. It then repeats that frame with an unread character in the register and drives `rd_strobe` on exactly that edge. The expected result is the new character in the register, `rx_done` still high and `overrun` low. A later read and a further frame then confirm that no loss was recorded.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rx_state_e;

  typedef struct packed {
    logic [8:0] bits;
    logic       stop;
  } rx_char_t;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b1;
          else     chain[0] <= din;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b1;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler
  import uart_rx_pkg::*;
#(
  parameter int OSR_SLOW = 16,
  parameter int OSR_FAST = 8
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     enable,
  input  logic     tick,
  input  logic     fast,
  input  logic     nine,
  input  logic     rxd,
  output logic     char_valid,
  output rx_char_t char_out
);
  localparam int CW = $clog2(OSR_SLOW);

  rx_state_e      state;
  logic [CW-1:0]  cnt;
  logic [3:0]     bit_idx;
  logic [8:0]     shreg;
  logic           smp_a, smp_b;
  logic           rxd_q;
  logic [CW-1:0]  last_c, mid_c;
  logic [3:0]     last_idx;
  logic           vote;

  assign last_c   = fast ? CW'(OSR_FAST - 1) : CW'(OSR_SLOW - 1);
  assign mid_c    = fast ? CW'(OSR_FAST / 2) : CW'(OSR_SLOW / 2);
  assign last_idx = nine ? 4'd8 : 4'd7;
  assign vote     = (smp_a & smp_b) | (smp_a & rxd) | (smp_b & rxd);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      bit_idx    <= '0;
      shreg      <= '0;
      smp_a      <= 1'b1;
      smp_b      <= 1'b1;
      rxd_q      <= 1'b1;
      char_valid <= 1'b0;
      char_out   <= '0;
    end else begin
      char_valid <= 1'b0;
      if (tick) rxd_q <= rxd;
      if (!enable) begin
        state <= ST_IDLE;
      end else if (tick) begin
        if (state == ST_IDLE) begin
          if (rxd_q && !rxd) begin
            state <= ST_START;
            cnt   <= '0;
          end
        end else begin
          cnt <= (cnt == last_c) ? '0 : cnt + 1'b1;
          if (cnt == mid_c - 1'b1) smp_a <= rxd;
          if (cnt == mid_c)        smp_b <= rxd;
          if (cnt == mid_c + 1'b1) begin
            case (state)
              ST_START: if (vote) state <= ST_IDLE;
              ST_DATA:  shreg[bit_idx] <= vote;
              ST_STOP: begin
                char_valid    <= 1'b1;
                char_out.bits <= shreg;
                char_out.stop <= vote;
                state         <= ST_IDLE;
              end
              default: state <= ST_IDLE;
            endcase
          end
          if (cnt == last_c) begin
            if (state == ST_START) begin
              state   <= ST_DATA;
              bit_idx <= '0;
              shreg   <= '0;
            end else if (state == ST_DATA) begin
              if (bit_idx == last_idx) state <= ST_STOP;
              else bit_idx <= bit_idx + 1'b1;
            end
          end
        end
      end
    end
  end

  // R1: a completed frame is reported for exactly one cycle
  a_r1_single_pulse: assert property (@(posedge clk) disable iff (rst)
    char_valid |=> !char_valid);

  // R10: no frame completes while the receiver is disabled
  a_r10_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !char_valid);
endmodule

// File: rtl/uart_rx_holdreg.sv
module uart_rx_holdreg
  import uart_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       enable,
  input  logic       nine,
  input  logic       mp_mode,
  input  logic       irq_en,
  input  logic       rd_strobe,
  input  logic       char_valid,
  input  rx_char_t   char_in,
  output logic [7:0] data,
  output logic       bit8,
  output logic       done,
  output logic       fe,
  output logic       ovr,
  output logic       irq
);
  logic mark, accept, xfer, lost, rd_hit, done_nxt, pend;

  assign mark     = nine ? char_in.bits[8] : char_in.stop;
  assign accept   = char_valid & enable & (!mp_mode | mark);
  assign xfer     = accept & (!done | rd_strobe);
  assign lost     = accept & done & !rd_strobe;
  assign rd_hit   = rd_strobe & done;
  assign done_nxt = xfer ? 1'b1 : (rd_hit ? 1'b0 : done);

  always_ff @(posedge clk) begin
    if (rst) begin
      data <= '0;
      bit8 <= 1'b0;
      done <= 1'b0;
      fe   <= 1'b0;
      ovr  <= 1'b0;
      pend <= 1'b0;
      irq  <= 1'b0;
    end else begin
      done <= done_nxt;
      irq  <= done_nxt & irq_en;
      if (xfer) begin
        data <= char_in.bits[7:0];
        bit8 <= nine & char_in.bits[8];
        fe   <= !char_in.stop;
        ovr  <= pend;
        pend <= 1'b0;
      end else if (lost) begin
        pend <= 1'b1;
      end
    end
  end

  // R11: interrupt request only with an unread character
  a_r11_irq_needs_done: assert property (@(posedge clk) disable iff (rst)
    irq |-> done);

  // R6: a read with no competing arrival empties the register
  a_r6_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && done && !char_valid) |=> !done);

  // R4: status flags move only when a character arrives
  a_r4_flags_hold: assert property (@(posedge clk) disable iff (rst)
    !char_valid |=> ($stable(fe) && $stable(ovr)));

  // R10: nothing becomes ready while disabled
  a_r10_no_set_when_off: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !$rose(done));

  // R7: a loss becomes visible only with a held character
  a_r7_ovr_with_char: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr) |-> done);
endmodule

// File: rtl/uart_rx_mp.sv
module uart_rx_mp
  import uart_rx_pkg::*;
#(
  parameter int OSR_SLOW    = 16,
  parameter int OSR_FAST    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       baud_tick,
  input  logic       rx_in,
  input  logic       rx_en,
  input  logic       dbl_speed,
  input  logic       nine_bit,
  input  logic       mp_mode,
  input  logic       rx_irq_en,
  input  logic       rd_strobe,
  output logic [7:0] rx_data,
  output logic       rx_bit8,
  output logic       rx_done,
  output logic       frame_err,
  output logic       overrun,
  output logic       rx_irq
);
  logic     rxd_s;
  logic     cv;
  rx_char_t ch;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (rx_in),
    .dout (rxd_s)
  );

  uart_rx_sampler #(.OSR_SLOW(OSR_SLOW), .OSR_FAST(OSR_FAST)) u_sampler (
    .clk        (clk),
    .rst        (rst),
    .enable     (rx_en),
    .tick       (baud_tick),
    .fast       (dbl_speed),
    .nine       (nine_bit),
    .rxd        (rxd_s),
    .char_valid (cv),
    .char_out   (ch)
  );

  uart_rx_holdreg u_hold (
    .clk        (clk),
    .rst        (rst),
    .enable     (rx_en),
    .nine       (nine_bit),
    .mp_mode    (mp_mode),
    .irq_en     (rx_irq_en),
    .rd_strobe  (rd_strobe),
    .char_valid (cv),
    .char_in    (ch),
    .data       (rx_data),
    .bit8       (rx_bit8),
    .done       (rx_done),
    .fe         (frame_err),
    .ovr        (overrun),
    .irq        (rx_irq)
  );
endmodule

// File: tb/uart_rx_mp_bench.sv
module uart_rx_mp_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic baud_tick;
  logic rx_in = 1'b1, rx_en = 1'b0, dbl_speed = 1'b0, nine_bit = 1'b0;
  logic mp_mode = 1'b0, rx_irq_en = 1'b0, rd_strobe = 1'b0;
  logic [7:0] rx_data;
  logic rx_bit8, rx_done, frame_err, overrun, rx_irq;

  int n_chk = 0;
  int n_bad = 0;
  int tcnt  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_ff @(posedge clk) tcnt <= (tcnt == TICK_DIV - 1) ? 0 : tcnt + 1;
  assign baud_tick = (tcnt == 0);

  uart_rx_mp u_uart_rx_mp (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .rx_in(rx_in),
    .rx_en(rx_en), .dbl_speed(dbl_speed), .nine_bit(nine_bit),
    .mp_mode(mp_mode), .rx_irq_en(rx_irq_en), .rd_strobe(rd_strobe),
    .rx_data(rx_data), .rx_bit8(rx_bit8), .rx_done(rx_done),
    .frame_err(frame_err), .overrun(overrun), .rx_irq(rx_irq)
  );

  typedef struct packed {
    logic       nine;
    logic       dbl;
    logic       mp;
    logic       stop;
    logic [8:0] d;
    logic       acc;
    logic       fe;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{1'b0, 1'b0, 1'b0, 1'b1, 9'h0A5, 1'b1, 1'b0},
    '{1'b0, 1'b1, 1'b0, 1'b1, 9'h03C, 1'b1, 1'b0},
    '{1'b1, 1'b0, 1'b0, 1'b1, 9'h1C3, 1'b1, 1'b0},
    '{1'b1, 1'b1, 1'b0, 1'b1, 9'h07E, 1'b1, 1'b0},
    '{1'b0, 1'b0, 1'b0, 1'b0, 9'h055, 1'b1, 1'b1},
    '{1'b1, 1'b0, 1'b1, 1'b1, 9'h012, 1'b0, 1'b0},
    '{1'b1, 1'b0, 1'b1, 1'b1, 9'h134, 1'b1, 1'b0},
    '{1'b0, 1'b1, 1'b1, 1'b1, 9'h0F0, 1'b1, 1'b0},
    '{1'b0, 1'b0, 1'b1, 1'b0, 9'h0AA, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic align();
    @(negedge clk);
    while (tcnt != 0) @(negedge clk);
  endtask

  task automatic send(input logic [8:0] d, input logic stop);
    int bclk;
    bclk = (dbl_speed ? 8 : 16) * TICK_DIV;
    rx_in = 1'b0;
    repeat (bclk) @(negedge clk);
    for (int i = 0; i < (nine_bit ? 9 : 8); i++) begin
      rx_in = d[i];
      repeat (bclk) @(negedge clk);
    end
    rx_in = stop;
    repeat (bclk) @(negedge clk);
    rx_in = 1'b1;
    repeat (bclk) @(negedge clk);
  endtask

  task automatic do_read();
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
    @(negedge clk);
  endtask

  logic [7:0] last_data;
  logic       last_fe;
  int         k;

  initial begin
    repeat (4) @(negedge clk);
    // R12 reset state
    chk("R12 done", {15'd0, rx_done}, 16'd0);
    chk("R12 flags", {13'd0, frame_err, overrun, rx_irq}, 16'd0);
    chk("R12 data", {7'd0, rx_bit8, rx_data}, 16'd0);
    rst = 1'b0;
    rx_en = 1'b1;
    rx_irq_en = 1'b1;
    repeat (4) @(negedge clk);

    // table walk: R1 R2 R4 R5 R9 R11 R6
    last_data = 8'h00;
    last_fe   = 1'b0;
    for (int v = 0; v < 9; v++) begin
      nine_bit  = VEC[v].nine;
      dbl_speed = VEC[v].dbl;
      mp_mode   = VEC[v].mp;
      align();
      send(VEC[v].d, VEC[v].stop);
      chk("R1/R9 done", {15'd0, rx_done}, {15'd0, VEC[v].acc});
      chk("R11 irq", {15'd0, rx_irq}, {15'd0, VEC[v].acc});
      if (VEC[v].acc) begin
        chk("R1/R2 data", {8'd0, rx_data}, {8'd0, VEC[v].d[7:0]});
        chk("R5 bit8", {15'd0, rx_bit8}, {15'd0, VEC[v].nine & VEC[v].d[8]});
        chk("R4 fe", {15'd0, frame_err}, {15'd0, VEC[v].fe});
        last_data = VEC[v].d[7:0];
        last_fe   = VEC[v].fe;
        do_read();
        chk("R6 read clears", {15'd0, rx_done}, 16'd0);
        chk("R11 irq drops", {15'd0, rx_irq}, 16'd0);
      end else begin
        chk("R9 data kept", {8'd0, rx_data}, {8'd0, last_data});
        chk("R9 fe kept", {15'd0, frame_err}, {15'd0, last_fe});
      end
    end
    nine_bit = 1'b0; dbl_speed = 1'b0; mp_mode = 1'b0;

    // R6 read while empty has no effect
    do_read();
    chk("R6 empty read", {7'd0, rx_done, rx_data}, {8'd0, last_data});

    // R3 false start glitch then a valid frame
    align();
    rx_in = 1'b0;
    repeat (3 * TICK_DIV) @(negedge clk);
    rx_in = 1'b1;
    repeat (40 * TICK_DIV) @(negedge clk);
    chk("R3 glitch ignored", {15'd0, rx_done}, 16'd0);
    align();
    send(9'h069, 1'b1);
    chk("R3 after glitch", {7'd0, rx_done, rx_data}, {8'd1, 8'h69});
    do_read();

    // R7 buffered overrun
    align(); send(9'h011, 1'b1);
    align(); send(9'h022, 1'b1);
    chk("R7 unread kept", {8'd0, rx_data}, 16'h0011);
    chk("R7 ovr hidden", {14'd0, rx_done, overrun}, 16'b10);
    do_read();
    align(); send(9'h033, 1'b1);
    chk("R7 ovr shown", {7'd0, overrun, rx_data}, {8'd1, 8'h33});
    do_read();
    align(); send(9'h044, 1'b1);
    chk("R7 ovr cleared", {7'd0, overrun, rx_data}, {8'd0, 8'h44});
    do_read();

    // R10 disabled: flags frozen, nothing received, no loss recorded
    align(); send(9'h0E1, 1'b0);
    chk("R10 pre fe", {14'd0, rx_done, frame_err}, 16'b11);
    rx_en = 1'b0;
    align(); send(9'h0B2, 1'b1);
    chk("R10 held", {6'd0, rx_done, frame_err, rx_data}, {8'b11, 8'hE1});
    chk("R10 no ovr", {15'd0, overrun}, 16'd0);
    rx_en = 1'b1;
    do_read();
    align(); send(9'h0C4, 1'b1);
    chk("R10 no loss", {7'd0, overrun, rx_data}, {8'd0, 8'hC4});
    do_read();

    // R11 irq disabled
    rx_irq_en = 1'b0;
    align(); send(9'h05A, 1'b1);
    chk("R11 masked", {14'd0, rx_done, rx_irq}, 16'b10);
    do_read();

    // R8 coincident read and completion: measure arrival edge
    k = 0;
    align();
    fork
      send(9'h07A, 1'b1);
      begin
        while (!rx_done) begin @(negedge clk); k++; end
      end
    join
    // register now holds 0x7A unread; repeat with read on the same edge
    align();
    fork
      send(9'h07B, 1'b1);
      begin
        repeat (k - 1) @(negedge clk);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        chk("R8 new char", {7'd0, rx_done, rx_data}, {8'd1, 8'h7B});
        chk("R8 no ovr", {15'd0, overrun}, 16'd0);
      end
    join
    do_read();
    chk("R8 read empties", {15'd0, rx_done}, 16'd0);
    align(); send(9'h07C, 1'b1);
    chk("R8 no pending loss", {7'd0, overrun, rx_data}, {8'd0, 8'h7C});

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule